// File: doc/BRIEF.md
# Bouncing Enlarged-Text Sprite

This block places a word of four characters on a 640x480 raster and moves it around the screen. The word sits in a bounding box that is never drawn. The video timing logic supplies the current pixel coordinates and a strobe at the start of each frame. On every strobe the box moves one pixel along each axis. When the box reaches a screen edge, the direction on that axis reverses, so the word appears to bounce.

For each pixel the block forms an address into an external 8x8 character table. The address combines a 4-bit character code and a 3-bit glyph row. The table returns one 8-bit row of the glyph. The block then raises a flag when the current pixel falls on a lit dot of the glyph.

The word is drawn eight times larger than the font. This comes from dropping the three low bits of the pixel's offset inside the box before the table lookup, so no scaler is needed. Address and flag follow the pixel coordinates within the same cycle. The only state is the box position and its two direction flags. The font table and colour mixing sit outside the block.

Top module: `bounce_text_sprite`

## Requirements
- R1: After reset the box's top-left corner is at (100, 50) and both axes move in the positive direction, so the first strobe moves the box to (101, 51).
- R2: The box position changes only in a cycle where `frame_start` is high, and each such cycle moves each axis by exactly one pixel.
- R3: When the box X position is 384 (right edge of box at pixel 639) and X is moving positive, the next strobe sets X to 383 and X moves negative from then on.
- R4: When the box X position is 0 and X is moving negative, the next strobe sets X to 1 and X moves positive from then on.
- R5: On the Y axis the box turns in the same way: from 416 (bottom edge of box at row 479) it goes to 415 and moves negative, and from 0 it goes to 1 and moves positive.
- R6: The box is 256 by 64 pixels and always lies fully on screen: 0 <= X <= 384 and 0 <= Y <= 416.
- R7: Inside the box, with offsets dx = pix_x - X and dy = pix_y - Y, `glyph_addr[6:3]` is the code of character dx/64 and `glyph_addr[2:0]` is (dy/8) mod 8. Character 0 is leftmost, and character i takes its code from bits [4i+3:4i] of the TEXT parameter (default codes 5, A, C, 3 from left to right).
- R8: Inside the box, `sprite_on` equals `glyph_row[7 - ((dx/8) mod 8)]`, so bit 7 of the row is the leftmost glyph column. Address and flag respond to the pixel coordinates in the same cycle.
- R9: `sprite_on` is 0 for every pixel outside the box and for every pixel outside the visible area (pix_x >= 640 or pix_y >= 480).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_x | input | 10 | Current pixel column |
| pix_y | input | 10 | Current pixel row |
| frame_start | input | 1 | One-cycle strobe per frame; moves the box |
| glyph_row | input | 8 | Row bits returned by the character table, bit 7 leftmost |
| glyph_addr | output | 7 | Character table address: {code[3:0], row[2:0]} |
| sprite_on | output | 1 | High when the current pixel is a lit glyph dot |

## Verification
The checker evaluates on every clock cycle the rules that concern the position alone. These are the on-screen bounds, the absence of movement without a strobe, the single-pixel step per strobe, and the turnarounds at all four edges. It also checks that the flag stays low off the visible area on every cycle.

The glyph addressing cannot be checked this way. Neither can the bit-7-leftmost order, the exact corner pixels of the box, or the reset position. These are shown only by the bench, which moves the box through full bounces on both axes and probes pixels just inside and just outside each box edge. It also sweeps whole boxes against a computed font pattern.

// File: rtl/bts_pkg.sv
package bts_pkg;

    localparam int unsigned COORD_W  = 10;
    localparam int unsigned H_VIS    = 640;
    localparam int unsigned V_VIS    = 480;
    localparam int unsigned SCALE_SH = 3;   // magnification = 2**SCALE_SH
    localparam int unsigned CELL_SH  = 3;   // glyph cell = 2**CELL_SH dots
    localparam int unsigned CODE_W   = 4;
    localparam int unsigned ROW_W    = CELL_SH;
    localparam int unsigned COL_W    = CELL_SH;
    localparam int unsigned GROW_W   = 1 << CELL_SH;
    localparam int unsigned ADDR_W   = CODE_W + ROW_W;

    typedef logic [COORD_W-1:0] coord_t;

    typedef struct packed {
        coord_t pos;
        logic   fwd;
    } axis_state_t;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [ROW_W-1:0]  row;
    } glyph_addr_t;

    // One frame step of a bouncing coordinate confined to [0, lim].
    function automatic axis_state_t axis_next(axis_state_t s, coord_t lim);
        axis_state_t n;
        n = s;
        if (s.fwd) begin
            if (s.pos >= lim) begin
                n.fwd = 1'b0;
                n.pos = s.pos - coord_t'(1);
            end else begin
                n.pos = s.pos + coord_t'(1);
            end
        end else begin
            if (s.pos == '0) begin
                n.fwd = 1'b1;
                n.pos = coord_t'(1);
            end else begin
                n.pos = s.pos - coord_t'(1);
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/bts_axis.sv
module bts_axis
    import bts_pkg::*;
#(
    parameter int unsigned LIMIT = 384,
    parameter int unsigned START = 100
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   step,
    output coord_t pos
);
    localparam coord_t LIM_C   = coord_t'(LIMIT);
    localparam coord_t START_C = coord_t'(START);

    axis_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pos <= START_C;
            st_q.fwd <= 1'b1;
        end else if (step) begin
            st_q <= axis_next(st_q, LIM_C);
        end
    end

    assign pos = st_q.pos;
endmodule

// File: rtl/bts_window.sv
module bts_window
    import bts_pkg::*;
#(
    parameter int unsigned BOX_W = 256,
    parameter int unsigned BOX_H = 64,
    parameter int unsigned IDX_W = 2
) (
    input  coord_t             pix_x,
    input  coord_t             pix_y,
    input  coord_t             box_x,
    input  coord_t             box_y,
    output logic               hit,
    output logic [IDX_W-1:0]   char_idx,
    output logic [COL_W-1:0]   gcol,
    output logic [ROW_W-1:0]   grow
);
    localparam coord_t BOX_W_C = coord_t'(BOX_W);
    localparam coord_t BOX_H_C = coord_t'(BOX_H);
    localparam coord_t H_VIS_C = coord_t'(H_VIS);
    localparam coord_t V_VIS_C = coord_t'(V_VIS);

    coord_t dx;
    coord_t dy;
    logic   visible;
    logic   in_x;
    logic   in_y;

    always_comb begin
        dx      = pix_x - box_x;
        dy      = pix_y - box_y;
        visible = (pix_x < H_VIS_C) && (pix_y < V_VIS_C);
        in_x    = (pix_x >= box_x) && (dx < BOX_W_C);
        in_y    = (pix_y >= box_y) && (dy < BOX_H_C);
        hit     = visible && in_x && in_y;
        // Discarding the low SCALE_SH bits magnifies the glyph.
        gcol     = dx[SCALE_SH +: COL_W];
        char_idx = dx[SCALE_SH + CELL_SH +: IDX_W];
        grow     = dy[SCALE_SH +: ROW_W];
    end
endmodule

// File: rtl/bts_glyph_pick.sv
module bts_glyph_pick
    import bts_pkg::*;
#(
    parameter int unsigned NCHARS = 4,
    parameter int unsigned IDX_W  = 2,
    parameter logic [NCHARS*CODE_W-1:0] TEXT = 16'h3CA5
) (
    input  logic               hit,
    input  logic [IDX_W-1:0]   char_idx,
    input  logic [COL_W-1:0]   gcol,
    input  logic [ROW_W-1:0]   grow,
    input  logic [GROW_W-1:0]  glyph_row,
    output glyph_addr_t        addr,
    output logic               lit
);
    logic [CODE_W-1:0] code;

    always_comb begin
        code = '0;
        for (int i = 0; i < NCHARS; i++) begin
            if (char_idx == IDX_W'(i)) code = TEXT[i*CODE_W +: CODE_W];
        end
        addr.code = code;
        addr.row  = grow;
        // Bit GROW_W-1 is the leftmost dot of the row.
        lit = hit && glyph_row[~gcol];
    end
endmodule

// File: rtl/bounce_text_sprite.sv
module bounce_text_sprite
    import bts_pkg::*;
#(
    parameter int unsigned NCHARS  = 4,
    parameter logic [NCHARS*CODE_W-1:0] TEXT = 16'h3CA5,
    parameter int unsigned START_X = 100,
    parameter int unsigned START_Y = 50
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [COORD_W-1:0]   pix_x,
    input  logic [COORD_W-1:0]   pix_y,
    input  logic                 frame_start,
    input  logic [GROW_W-1:0]    glyph_row,
    output logic [ADDR_W-1:0]    glyph_addr,
    output logic                 sprite_on
);
    localparam int unsigned IDX_W = (NCHARS > 1) ? $clog2(NCHARS) : 1;
    localparam int unsigned BOX_W = NCHARS << (SCALE_SH + CELL_SH);
    localparam int unsigned BOX_H = 1 << (SCALE_SH + CELL_SH);
    localparam int unsigned X_LIM = H_VIS - BOX_W;
    localparam int unsigned Y_LIM = V_VIS - BOX_H;

    coord_t axis_pos [2];
    coord_t box_x;
    coord_t box_y;

    for (genvar g = 0; g < 2; g++) begin : g_axis
        bts_axis #(
            .LIMIT (g == 0 ? X_LIM : Y_LIM),
            .START (g == 0 ? START_X : START_Y)
        ) u_axis (
            .clk  (clk),
            .rst  (rst),
            .step (frame_start),
            .pos  (axis_pos[g])
        );
    end

    assign box_x = axis_pos[0];
    assign box_y = axis_pos[1];

    logic             hit;
    logic [IDX_W-1:0] char_idx;
    logic [COL_W-1:0] gcol;
    logic [ROW_W-1:0] grow;
    glyph_addr_t      addr;

    bts_window #(
        .BOX_W (BOX_W),
        .BOX_H (BOX_H),
        .IDX_W (IDX_W)
    ) u_window (
        .pix_x    (pix_x),
        .pix_y    (pix_y),
        .box_x    (box_x),
        .box_y    (box_y),
        .hit      (hit),
        .char_idx (char_idx),
        .gcol     (gcol),
        .grow     (grow)
    );

    bts_glyph_pick #(
        .NCHARS (NCHARS),
        .IDX_W  (IDX_W),
        .TEXT   (TEXT)
    ) u_pick (
        .hit       (hit),
        .char_idx  (char_idx),
        .gcol      (gcol),
        .grow      (grow),
        .glyph_row (glyph_row),
        .addr      (addr),
        .lit       (sprite_on)
    );

    assign glyph_addr = addr;
endmodule

// File: rtl/bts_checker.sv
module bts_checker
    import bts_pkg::*;
#(
    parameter int unsigned X_LIM = 384,
    parameter int unsigned Y_LIM = 416
) (
    input logic   clk,
    input logic   rst,
    input logic   frame_start,
    input coord_t pix_x,
    input coord_t pix_y,
    input logic   sprite_on,
    input coord_t box_x,
    input coord_t box_y
);
    localparam coord_t XL = coord_t'(X_LIM);
    localparam coord_t YL = coord_t'(Y_LIM);

    AST_X_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        box_x <= XL); // R6
    AST_Y_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        box_y <= YL); // R6
    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(box_x) && $stable(box_y)); // R2
    AST_X_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (box_x == $past(box_x) + coord_t'(1)) || (box_x == $past(box_x) - coord_t'(1))); // R2
    AST_Y_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (box_y == $past(box_y) + coord_t'(1)) || (box_y == $past(box_y) - coord_t'(1))); // R2
    AST_X_RIGHT_TURN: assert property (@(posedge clk) disable iff (rst)
        frame_start && box_x == XL |=> box_x == XL - coord_t'(1)); // R3
    AST_X_LEFT_TURN: assert property (@(posedge clk) disable iff (rst)
        frame_start && box_x == '0 |=> box_x == coord_t'(1)); // R4
    AST_Y_BOTTOM_TURN: assert property (@(posedge clk) disable iff (rst)
        frame_start && box_y == YL |=> box_y == YL - coord_t'(1)); // R5
    AST_Y_TOP_TURN: assert property (@(posedge clk) disable iff (rst)
        frame_start && box_y == '0 |=> box_y == coord_t'(1)); // R5
    AST_DARK_OFFSCREEN: assert property (@(posedge clk) disable iff (rst)
        (pix_x >= coord_t'(H_VIS) || pix_y >= coord_t'(V_VIS)) |-> !sprite_on); // R9
endmodule

bind bounce_text_sprite bts_checker #(
    .X_LIM (X_LIM),
    .Y_LIM (Y_LIM)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .pix_x       (pix_x),
    .pix_y       (pix_y),
    .sprite_on   (sprite_on),
    .box_x       (box_x),
    .box_y       (box_y)
);

// File: tb/bounce_text_sprite_bench.sv
module bounce_text_sprite_bench;
    localparam int CLK_PERIOD = 10;
    localparam int XMAX = 384;
    localparam int YMAX = 416;
    localparam logic [15:0] TEXT_C = 16'h3CA5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] pix_x = '0;
    logic [9:0] pix_y = '0;
    logic       frame_start = 1'b0;
    logic [7:0] glyph_row;
    logic [6:0] glyph_addr;
    logic       sprite_on;

    logic       all_ones = 1'b1;
    int         total = 0;
    int         failed = 0;
    int         cycles = 0;
    bit         done = 0;

    int mx, my;
    bit mfx, mfy;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] pat(input logic [6:0] a);
        return 8'(({1'b0, a} * 8'd37) ^ 8'hC3);
    endfunction

    always_comb glyph_row = all_ones ? 8'hFF : pat(glyph_addr);

    bounce_text_sprite u_bounce_text_sprite (
        .clk         (clk),
        .rst         (rst),
        .pix_x       (pix_x),
        .pix_y       (pix_y),
        .frame_start (frame_start),
        .glyph_row   (glyph_row),
        .glyph_addr  (glyph_addr),
        .sprite_on   (sprite_on)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            failed++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic probe(input int x, input int y, input int exp, input string tag);
        pix_x = 10'(x);
        pix_y = 10'(y);
        #1;
        chk($sformatf("%s on(%0d,%0d)", tag, x, y), int'(sprite_on), exp);
    endtask

    // Box edges with an all-lit font: R6 bounds, corners and neighbours (R9)
    task automatic probe_box(input string tag);
        probe(mx, my, 1, tag);
        probe(mx + 255, my + 63, 1, tag);
        probe(mx + 256, my, 0, {tag, "/R9"});
        probe(mx, my + 64, 0, {tag, "/R9"});
        if (mx > 0) probe(mx - 1, my, 0, {tag, "/R9"});
        if (my > 0) probe(mx, my - 1, 0, {tag, "/R9"});
    endtask

    function automatic string model_step();
        string t;
        t = "R2";
        if (mfx) begin
            if (mx == XMAX) begin mfx = 0; mx = XMAX - 1; t = "R3"; end
            else mx++;
        end else begin
            if (mx == 0) begin mfx = 1; mx = 1; t = "R4"; end
            else mx--;
        end
        if (mfy) begin
            if (my == YMAX) begin mfy = 0; my = YMAX - 1; t = "R5"; end
            else my++;
        end else begin
            if (my == 0) begin mfy = 1; my = 1; t = "R5"; end
            else my--;
        end
        return t;
    endfunction

    // Whole-box sweep with a patterned font: R7 address and R8 dot order
    task automatic sweep();
        all_ones = 1'b0;
        for (int dy = -4; dy < 68; dy++) begin
            for (int dx = -4; dx < 260; dx++) begin
                bit inb;
                int code, row, col, ebit;
                inb = (dx >= 0) && (dx < 256) && (dy >= 0) && (dy < 64);
                pix_x = 10'(mx + dx);
                pix_y = 10'(my + dy);
                #1;
                if (inb) begin
                    code = int'(TEXT_C[(dx / 64) * 4 +: 4]);
                    row  = (dy / 8) % 8;
                    col  = (dx / 8) % 8;
                    ebit = int'(pat(7'(code * 8 + row))[7 - col]);
                    chk($sformatf("R7 addr dx=%0d dy=%0d", dx, dy), int'(glyph_addr), code * 8 + row);
                    chk($sformatf("R8 on dx=%0d dy=%0d", dx, dy), int'(sprite_on), ebit);
                end else begin
                    chk($sformatf("R9 outside dx=%0d dy=%0d", dx, dy), int'(sprite_on), 0);
                end
            end
        end
        all_ones = 1'b1;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", total - failed, total);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            total++;
            failed++;
            $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
            summary();
            $finish;
        end
    end

    initial begin
        mx = 100; my = 50; mfx = 1; mfy = 1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        probe_box("R1 reset");
        probe(355, 113, 1, "R1 reset far corner");

        // No strobe for several cycles: box must hold (R2)
        repeat (6) @(negedge clk);
        probe_box("R2 hold");

        // Off-visible pixels (R9)
        probe(700, 60, 0, "R9 x>=640");
        probe(120, 500, 0, "R9 y>=480");
        probe(1023, 1023, 0, "R9 max coords");

        sweep();

        for (int f = 0; f < 900; f++) begin
            string t;
            @(negedge clk) frame_start = 1'b1;
            @(negedge clk) frame_start = 1'b0;
            t = model_step();
            if (f == 0) t = "R1 first step";
            probe_box(t);
            if (f == 289) sweep();
            if (f % 97 == 5) begin
                repeat (3) @(negedge clk);
                probe_box("R2 idle");
            end
        end

        done = 1;
        summary();
        $finish;
    end
endmodule